// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block keeps the eight status bits of an asynchronous serial port as one byte that the CPU can read at any time. Single-cycle event strobes from the transmit and receive shifters set the flags. The sticky flags (transmit-empty, receive-full, overrun, framing error, parity error) are cleared by a handshake: the CPU first reads the byte and sees the flag at 1, then writes 0 to that bit. A data-register access made by a DMA engine also clears the matching flag without any handshake.

Transmit-end and the received multiprocessor bit are read-only and follow the serial events. The multiprocessor-transfer bit is a plain read/write control bit that the transmitter sends with each frame. Two interrupt requests follow transmit-empty and receive-full.

Byte layout: bit0 transmit-empty, bit1 receive-full, bit2 overrun, bit3 framing error, bit4 parity error, bit5 transmit-end, bit6 received multiprocessor bit, bit7 multiprocessor-transfer bit.

Top module: `sio_status_reg`

## Requirements
- R1: After reset the byte reads 8'h21: bit0 (transmit-empty) and bit5 (transmit-end) are 1 and every other bit is 0.
- R2: Bits 0 to 4 are cleared by the CPU only by a write with 0 in that bit, made after a read that returned the bit as 1. Writing 1 has no effect. Writing 0 with no such earlier read has no effect.
- R3: Bit0 is set in any cycle where `tx_en` is 0, and when `tx_load` pulses.
- R4: A CPU clear of bit0 (per R2), or a `dma_tx_wr` pulse, clears both bit0 and bit5 unless a set event for that bit happens in the same cycle.
- R5: Bit1 is set on an `rx_done` with stop bit 1 and no parity error while bit1 is 0. A `dma_rx_rd` pulse clears bit1.
- R6: An `rx_done` while bit1 is 1 sets bit2, and bit1 stays 1.
- R7: An `rx_done` with `rx_stop_bit` at 0 sets bit3.
- R8: When `rx_parity_en` is 1, an `rx_done` sets bit4 if the count of ones in `rx_data` plus `rx_parity_bit` is even while `parity_odd` is 1, or odd while `parity_odd` is 0.
- R9: Bit5 is set while `tx_en` is 0, or when `tx_last_bit` pulses while bit0 is 1. CPU writes to bit5 are ignored.
- R10: Bit6 takes `rx_mp_bit` on every `rx_done`. Bit7 takes `cpu_wdata[7]` on every CPU write and drives `mp_tx_bit`.
- R11: A set event takes priority over a clear in the same cycle. A set event also withdraws an earlier read, so a new read is needed before a 0-write clears the flag.
- R12: `tx_irq` equals bit0 and `rx_irq` equals bit1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_rd | input | 1 | CPU read strobe for the status byte |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Status byte |
| tx_en | input | 1 | Transmitter enable |
| tx_load | input | 1 | Data register moved into the transmit shifter |
| tx_last_bit | input | 1 | Last bit of a character is being sent |
| dma_tx_wr | input | 1 | DMA write to the transmit data register |
| rx_done | input | 1 | Reception of a frame has completed |
| rx_data | input | DATA_W | Received data bits |
| rx_parity_en | input | 1 | Parity checking is enabled |
| parity_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| rx_parity_bit | input | 1 | Received parity bit |
| rx_stop_bit | input | 1 | Sampled stop bit |
| rx_mp_bit | input | 1 | Received multiprocessor bit |
| dma_rx_rd | input | 1 | DMA read of the receive data register |
| mp_tx_bit | output | 1 | Multiprocessor bit to send |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The bench builds the block with `DATA_W` set to 7, so the parity check runs over an odd data width. A 7-bit frame with the parity bit added gives an 8-bit ones count, which reaches both parity outcomes under both modes. Random phases mix read, write and event strobes in the same cycle. This covers the set-versus-clear collisions and the withdrawal of a read by a later set event, which directed sequences alone rarely line up.

// File: rtl/sio_status_pkg.sv
package sio_status_pkg;
  localparam int STS_W      = 8;
  localparam int NUM_STICKY = 5;
  localparam int B_TXE = 0;
  localparam int B_RXF = 1;
  localparam int B_OVR = 2;
  localparam int B_FRM = 3;
  localparam int B_PAR = 4;
  localparam int B_TND = 5;
  localparam int B_MPR = 6;
  localparam int B_MPT = 7;
  localparam logic [STS_W-1:0] STS_RESET = 8'h21;
endpackage

// File: rtl/sio_sticky_flag.sv
module sio_sticky_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic ext_clr,
  input  logic cpu_rd,
  input  logic cpu_wr,
  input  logic wr_bit,
  output logic q,
  output logic armed,
  output logic cpu_hit
);
  logic clr_hit;

  // CPU clear: a 0 written while the flag is 1 and a read saw it
  assign cpu_hit = cpu_wr & ~wr_bit & armed & q;
  assign clr_hit = cpu_hit | ext_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= RST_VAL;
      armed <= 1'b0;
    end else begin
      if (set_ev)       q <= 1'b1;
      else if (clr_hit) q <= 1'b0;

      if (set_ev)       armed <= 1'b0;
      else if (cpu_rd)  armed <= q;
      else if (clr_hit) armed <= 1'b0;
    end
  end
endmodule

// File: rtl/sio_rx_eval.sv
module sio_rx_eval #(
  parameter int DATA_W = 8
) (
  input  logic              rx_done,
  input  logic              rx_full,
  input  logic [DATA_W-1:0] data,
  input  logic              parity_en,
  input  logic              parity_odd,
  input  logic              parity_bit,
  input  logic              stop_bit,
  output logic              load_ev,
  output logic              overrun_ev,
  output logic              frame_ev,
  output logic              parity_ev
);
  function automatic logic parity_mismatch(input logic [DATA_W-1:0] d,
                                           input logic pb, input logic odd);
    return (^{d, pb}) != odd;
  endfunction

  assign parity_ev  = rx_done & parity_en & parity_mismatch(data, parity_bit, parity_odd);
  assign frame_ev   = rx_done & ~stop_bit;
  assign overrun_ev = rx_done & rx_full;
  assign load_ev    = rx_done & ~rx_full & stop_bit & ~parity_ev;
endmodule

// File: rtl/sio_tx_eval.sv
module sio_tx_eval (
  input  logic tx_en,
  input  logic tx_load,
  input  logic tx_last_bit,
  input  logic tx_empty,
  output logic txe_set,
  output logic tend_set
);
  assign txe_set  = ~tx_en | tx_load;
  assign tend_set = ~tx_en | (tx_last_bit & tx_empty);
endmodule

// File: rtl/sio_status_reg.sv
module sio_status_reg
  import sio_status_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  input  logic              tx_en,
  input  logic              tx_load,
  input  logic              tx_last_bit,
  input  logic              dma_tx_wr,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_parity_en,
  input  logic              parity_odd,
  input  logic              rx_parity_bit,
  input  logic              rx_stop_bit,
  input  logic              rx_mp_bit,
  input  logic              dma_rx_rd,
  output logic              mp_tx_bit,
  output logic              tx_irq,
  output logic              rx_irq
);
  logic [NUM_STICKY-1:0] sticky_q, sticky_set, sticky_ext, sticky_arm, sticky_cpu_hit;
  logic txe_set, tend_set;
  logic rx_load_ev, rx_ovr_ev, rx_frm_ev, rx_par_ev;
  logic tend_q, mpr_q, mpt_q;

  sio_tx_eval u_tx (
    .tx_en(tx_en), .tx_load(tx_load), .tx_last_bit(tx_last_bit),
    .tx_empty(sticky_q[B_TXE]), .txe_set(txe_set), .tend_set(tend_set)
  );

  sio_rx_eval #(.DATA_W(DATA_W)) u_rx (
    .rx_done(rx_done), .rx_full(sticky_q[B_RXF]), .data(rx_data),
    .parity_en(rx_parity_en), .parity_odd(parity_odd), .parity_bit(rx_parity_bit),
    .stop_bit(rx_stop_bit), .load_ev(rx_load_ev), .overrun_ev(rx_ovr_ev),
    .frame_ev(rx_frm_ev), .parity_ev(rx_par_ev)
  );

  assign sticky_set = {rx_par_ev, rx_frm_ev, rx_ovr_ev, rx_load_ev, txe_set};
  assign sticky_ext = {3'b000, dma_rx_rd, dma_tx_wr};

  for (genvar gi = 0; gi < NUM_STICKY; gi++) begin : g_sticky
    sio_sticky_flag #(.RST_VAL(STS_RESET[gi])) u_flag (
      .clk(clk), .rst_n(rst_n), .set_ev(sticky_set[gi]), .ext_clr(sticky_ext[gi]),
      .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .wr_bit(cpu_wdata[gi]),
      .q(sticky_q[gi]), .armed(sticky_arm[gi]), .cpu_hit(sticky_cpu_hit[gi])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tend_q <= STS_RESET[B_TND];
      mpr_q  <= STS_RESET[B_MPR];
      mpt_q  <= STS_RESET[B_MPT];
    end else begin
      if (tend_set)                                tend_q <= 1'b1;
      else if (sticky_cpu_hit[B_TXE] | dma_tx_wr)  tend_q <= 1'b0;
      if (rx_done) mpr_q <= rx_mp_bit;
      if (cpu_wr)  mpt_q <= cpu_wdata[B_MPT];
    end
  end

  assign cpu_rdata = {mpt_q, mpr_q, tend_q, sticky_q};
  assign mp_tx_bit = mpt_q;
  assign tx_irq    = sticky_q[B_TXE];
  assign rx_irq    = sticky_q[B_RXF];
endmodule

// File: rtl/sio_status_chk.sv
module sio_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] cpu_rdata,
  input logic       tx_en,
  input logic       tx_load,
  input logic       tx_last_bit,
  input logic       dma_rx_rd,
  input logic       rx_done,
  input logic       rx_stop_bit,
  input logic       rx_mp_bit,
  input logic [4:0] sticky_arm,
  input logic [4:0] sticky_cpu_hit
);
  p_reset_vals_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> cpu_rdata == 8'h21);

  p_idle_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> cpu_rdata[0] && cpu_rdata[5]);

  p_load_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> cpu_rdata[0]);

  p_hit_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_cpu_hit[4:1] != 4'd0 && !rx_done)
      |=> (cpu_rdata[4:1] & $past(sticky_cpu_hit[4:1])) == 4'd0);

  p_no_read_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rdata[1] && !sticky_arm[1] && !dma_rx_rd) |=> cpu_rdata[1]);

  p_tend_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_cpu_hit[0] && tx_en && !tx_last_bit) |=> !cpu_rdata[5]);

  p_dma_rx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_rx_rd && !rx_done) |=> !cpu_rdata[1]);

  p_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && cpu_rdata[1]) |=> cpu_rdata[2]);

  p_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !rx_stop_bit) |=> cpu_rdata[3]);

  p_tend_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_last_bit && cpu_rdata[0]) |=> cpu_rdata[5]);

  p_mp_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> cpu_rdata[6] == $past(rx_mp_bit));

  p_set_disarms_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && cpu_rdata[1]) |=> !sticky_arm[2]);
endmodule

bind sio_status_reg sio_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_rdata(cpu_rdata), .tx_en(tx_en),
  .tx_load(tx_load), .tx_last_bit(tx_last_bit), .dma_rx_rd(dma_rx_rd),
  .rx_done(rx_done), .rx_stop_bit(rx_stop_bit), .rx_mp_bit(rx_mp_bit),
  .sticky_arm(sticky_arm), .sticky_cpu_hit(sticky_cpu_hit)
);

// File: tb/sio_status_reg_test.sv
module sio_status_reg_test;
  localparam int DW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_rd = 0, cpu_wr = 0;
  logic [7:0] cpu_wdata = 0;
  logic [7:0] cpu_rdata;
  logic tx_en = 0, tx_load = 0, tx_last_bit = 0, dma_tx_wr = 0;
  logic rx_done = 0, rx_parity_en = 0, parity_odd = 0, rx_parity_bit = 0;
  logic rx_stop_bit = 1, rx_mp_bit = 0, dma_rx_rd = 0;
  logic [DW-1:0] rx_data = 0;
  logic mp_tx_bit, tx_irq, rx_irq;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sio_status_reg #(.DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .tx_en(tx_en),
    .tx_load(tx_load), .tx_last_bit(tx_last_bit), .dma_tx_wr(dma_tx_wr),
    .rx_done(rx_done), .rx_data(rx_data), .rx_parity_en(rx_parity_en),
    .parity_odd(parity_odd), .rx_parity_bit(rx_parity_bit),
    .rx_stop_bit(rx_stop_bit), .rx_mp_bit(rx_mp_bit), .dma_rx_rd(dma_rx_rd),
    .mp_tx_bit(mp_tx_bit), .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  // Behavioural reference: flag values and read-seen marks
  bit ref_flag [8];
  bit ref_seen [5];
  string bit_tag [8] = '{"R3", "R5", "R6", "R7", "R8", "R9", "R10", "R10"};

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (ref_flag[k]) ref_flag[k] = (k == 0 || k == 5);
      foreach (ref_seen[k]) ref_seen[k] = 0;
    end else begin
      bit rise [5];
      bit wipe [5];
      bit cpu_wipe [5];
      bit bad_par;
      bit nxt [8];
      int ones;
      ones = $countones(rx_data) + int'(rx_parity_bit);
      bad_par = rx_parity_en && ((ones % 2 == 1) != parity_odd);
      rise[0] = !tx_en || tx_load;
      rise[1] = rx_done && !ref_flag[1] && rx_stop_bit && !bad_par;
      rise[2] = rx_done && ref_flag[1];
      rise[3] = rx_done && !rx_stop_bit;
      rise[4] = rx_done && bad_par;
      for (int k = 0; k < 5; k++) begin
        cpu_wipe[k] = cpu_wr && !cpu_wdata[k] && ref_seen[k] && ref_flag[k];
        wipe[k] = cpu_wipe[k] || (k == 0 && dma_tx_wr) || (k == 1 && dma_rx_rd);
      end
      for (int k = 0; k < 5; k++) begin
        nxt[k] = rise[k] ? 1'b1 : (wipe[k] ? 1'b0 : ref_flag[k]);
        if (rise[k])      ref_seen[k] = 0;
        else if (cpu_rd)  ref_seen[k] = ref_flag[k];
        else if (wipe[k]) ref_seen[k] = 0;
      end
      if (!tx_en || (tx_last_bit && ref_flag[0])) nxt[5] = 1;
      else if (cpu_wipe[0] || dma_tx_wr)          nxt[5] = 0;
      else                                         nxt[5] = ref_flag[5];
      nxt[6] = rx_done ? rx_mp_bit : ref_flag[6];
      nxt[7] = cpu_wr ? cpu_wdata[7] : ref_flag[7];
      foreach (ref_flag[k]) ref_flag[k] = nxt[k];
    end
  end

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // Compare against the reference on every falling edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      for (int k = 0; k < 8; k++)
        check(bit_tag[k], {7'd0, cpu_rdata[k]}, {7'd0, ref_flag[k]});
      check("R12", {6'd0, tx_irq, rx_irq}, {6'd0, ref_flag[0], ref_flag[1]});
      check("R10", {7'd0, mp_tx_bit}, {7'd0, ref_flag[7]});
    end
  end

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic do_read();
    cpu_rd = 1; cyc(); cpu_rd = 0;
  endtask

  task automatic do_write(logic [7:0] d);
    cpu_wr = 1; cpu_wdata = d; cyc(); cpu_wr = 0;
  endtask

  task automatic frame(logic [DW-1:0] d, logic pb, logic stop, logic mp);
    rx_data = d; rx_parity_bit = pb; rx_stop_bit = stop; rx_mp_bit = mp;
    rx_done = 1; cyc(); rx_done = 0; rx_stop_bit = 1;
  endtask

  task automatic summary();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    #2;
    check("R1 reset", cpu_rdata, 8'h21);
    check("R12 reset irq", {6'd0, tx_irq, rx_irq}, 8'h02);

    // R2: 0-write without a read leaves bit0 set
    tx_en = 1;
    do_write(8'h00);
    check("R2 no read", {7'd0, cpu_rdata[0]}, 8'h01);

    // R4: handshake clears transmit-empty and transmit-end
    do_read();
    do_write(8'h00);
    check("R4 cpu clear", {6'd0, cpu_rdata[5], cpu_rdata[0]}, 8'h00);

    // R5 / R12: good frame sets receive-full
    frame(7'h05, 0, 1, 0);
    check("R5 load", {7'd0, cpu_rdata[1]}, 8'h01);
    check("R12 rx irq", {7'd0, rx_irq}, 8'h01);

    // R2: writing 1 after a read has no effect; R10 transfer bit
    do_read();
    do_write(8'hFF);
    check("R2 write one", {7'd0, cpu_rdata[1]}, 8'h01);
    check("R10 mp tx", {7'd0, mp_tx_bit}, 8'h01);

    // R6 overrun
    frame(7'h11, 0, 1, 0);
    check("R6 overrun", {6'd0, cpu_rdata[2], cpu_rdata[1]}, 8'h03);

    // R7 framing
    frame(7'h11, 0, 0, 0);
    check("R7 framing", {7'd0, cpu_rdata[3]}, 8'h01);

    // R8 odd parity, data with two ones and parity bit 0 is wrong
    rx_parity_en = 1; parity_odd = 1;
    frame(7'h03, 0, 1, 1);
    check("R8 parity", {7'd0, cpu_rdata[4]}, 8'h01);
    check("R10 mp rx", {7'd0, cpu_rdata[6]}, 8'h01);

    // R11: set wins over a same-cycle clear
    do_read();
    rx_data = 7'h03; rx_parity_bit = 1; rx_stop_bit = 1; rx_mp_bit = 0;
    rx_done = 1; cpu_wr = 1; cpu_wdata = 8'h80;
    cyc();
    rx_done = 0; cpu_wr = 0;
    check("R11 set wins", {7'd0, cpu_rdata[2]}, 8'h01);
    check("R2 cleared", {3'd0, cpu_rdata[4:0]}, 8'h04);

    // R11: set event after the read withdraws it
    frame(7'h03, 1, 1, 0);
    do_read();
    frame(7'h03, 1, 1, 0);
    do_write(8'h80);
    check("R11 disarm", {6'd0, cpu_rdata[2], cpu_rdata[1]}, 8'h02);

    // R5 DMA read
    frame(7'h03, 1, 1, 0);
    dma_rx_rd = 1; cyc(); dma_rx_rd = 0;
    check("R5 dma", {7'd0, cpu_rdata[1]}, 8'h00);

    // R3 / R9 / R4 transmit side
    tx_load = 1; cyc(); tx_load = 0;
    check("R3 load", {7'd0, cpu_rdata[0]}, 8'h01);
    tx_last_bit = 1; cyc(); tx_last_bit = 0;
    check("R9 last bit", {7'd0, cpu_rdata[5]}, 8'h01);
    dma_tx_wr = 1; cyc(); dma_tx_wr = 0;
    check("R4 dma", {6'd0, cpu_rdata[5], cpu_rdata[0]}, 8'h00);
    tx_last_bit = 1; cyc(); tx_last_bit = 0;
    check("R9 empty low", {7'd0, cpu_rdata[5]}, 8'h00);
    do_write(8'hFF);
    check("R9 write ignored", {7'd0, cpu_rdata[5]}, 8'h00);
    tx_en = 0; cyc();
    check("R3 idle", {6'd0, cpu_rdata[5], cpu_rdata[0]}, 8'h03);

    // Random mix against the reference
    for (int n = 0; n < 3000; n++) begin
      tx_en        = ($urandom_range(15) != 0);
      tx_load      = ($urandom_range(7) == 0);
      tx_last_bit  = ($urandom_range(5) == 0);
      dma_tx_wr    = ($urandom_range(11) == 0);
      rx_done      = ($urandom_range(4) == 0);
      rx_data      = DW'($urandom);
      rx_parity_en = $urandom_range(1);
      parity_odd   = $urandom_range(1);
      rx_parity_bit = $urandom_range(1);
      rx_stop_bit  = ($urandom_range(5) != 0);
      rx_mp_bit    = $urandom_range(1);
      dma_rx_rd    = ($urandom_range(9) == 0);
      cpu_rd       = ($urandom_range(2) == 0);
      cpu_wr       = ($urandom_range(2) == 0);
      cpu_wdata    = 8'($urandom);
      cyc();
    end
    cpu_rd = 0; cpu_wr = 0; rx_done = 0; tx_load = 0; tx_last_bit = 0;
    dma_tx_wr = 0; dma_rx_rd = 0;
    cyc();
    summary();
  end
endmodule